// File: doc/BRIEF.md
# Four-Wide Decode Slot Steering

This block sits between instruction length decode and micro-op allocation. Each cycle it looks at a window of already-delimited instructions, oldest first. For each one it knows the number of fused micro-ops the instruction needs and a small class code. It groups the oldest instructions onto four decode slots and presents that group as one registered output beat. It also reports how many window entries the group used, so that fetch can shift the window by that amount before the next cycle.

The slots are not alike. Slot 0 is the complex slot: it takes whatever instruction is oldest and may emit one to four micro-ops for it. Slots 1 to 3 are simple and only take an instruction that maps to exactly one micro-op. A compare that is directly followed in the window by a conditional jump is merged into one single-micro-op unit before slots are assigned. An instruction needing more than four micro-ops raises a microcode-escape flag and goes alone in slot 0.

The output is valid/ready. A beat stays on the output, unchanged, until `out_ready` is high at a clock edge. A new group is formed and window entries are consumed only in a cycle where the output register is empty or is being drained in that same cycle. When the window's oldest entry is not valid, no group is formed and nothing is consumed.

Top module: `dec_slot_steer`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `take_cnt` are 0. After reset, `out_valid` stays 0 until a group has been formed.
- R2: Slot 0 always holds the oldest window entry. Its micro-op count field equals that entry's count (3-bit field, legal values 1 to 7).
- R3: Slots 1 to 3 only hold units of one micro-op. When a younger instruction with a count above 1 is reached, the group ends before it, and that instruction is the oldest entry (slot 0) of a later group.
- R4: An entry of class 1 (compare) with count 1, directly followed in the window by a valid entry of class 2 (conditional jump) with count 1, forms one unit. That unit has a count of 1, sets the slot's fused bit, reports the compare's window position and uses two window entries. A compare in the last valid position is not fused. Classes 0 and 3 are ordinary instructions.
- R5: Slots fill from slot 0 without gaps, in program order. Each slot's window position is larger than the previous slot's, and the units of a group cover consecutive window entries starting at position 0.
- R6: When the oldest entry's count is above 4, `out_escape` is 1 and only slot 0 is valid for that beat.
- R7: While `out_valid` is 1 and `out_ready` is 0, every output field keeps its value and `take_cnt` is 0.
- R8: `take_cnt` equals the number of window entries covered by the group being loaded (a fused pair counts 2). It is nonzero exactly when the output register is free (empty, or `out_ready` high) and window entry 0 is valid.
- R9: When the output register is free and window entry 0 is not valid, `out_valid` goes to 0 at the next edge. Window valid bits are contiguous from position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_vld | input | WIN | Per-entry valid, bit 0 is the oldest entry |
| win_uops | input | WIN*UW | Per-entry micro-op count, entry i at bits [i*UW +: UW] |
| win_cls | input | WIN*2 | Per-entry class: 0 plain, 1 compare, 2 conditional jump, 3 other |
| take_cnt | output | $clog2(WIN)+1 | Window entries consumed this cycle |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_slot_vld | output | SLOTS | Per-slot valid |
| out_slot_pos | output | SLOTS*$clog2(WIN) | Per-slot window position at the time of the take |
| out_slot_uops | output | SLOTS*UW | Per-slot micro-op count |
| out_slot_fused | output | SLOTS | Per-slot compare-and-jump fused bit |
| out_escape | output | 1 | Slot 0 instruction needs more than four micro-ops |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- A multi-micro-op instruction behind a simple one. A design that ignored slot asymmetry would put it in slot 1.
- A compare sitting at the last valid window position. A design that fused it anyway would consume a jump it never saw.
- A compare of more than one micro-op followed by a jump. A design that fused on class alone would emit a wrong count.
- An escape instruction followed by simple instructions. A design that kept filling slots would break the alone-in-slot-0 rule.

Fetch bubbles that shrink the window, and long stretches of low `out_ready`, show whether the design consumes entries while stalled or drops a held beat. The reference model steers every window on its own and compares every output field each cycle.

// File: rtl/dec_slot_pkg.sv
package dec_slot_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_CMP   = 2'd1,
    CLS_JCC   = 2'd2,
    CLS_OTHER = 2'd3
  } insn_cls_t;
endpackage

// File: rtl/dec_fuse_detect.sv
module dec_fuse_detect #(
  parameter int WIN = 6,
  parameter int UW  = 3
) (
  input  logic [WIN-1:0] vld,
  input  logic [UW-1:0]  uops [WIN],
  input  logic [1:0]     cls  [WIN],
  output logic [WIN-1:0] pair_head
);
  import dec_slot_pkg::*;
  localparam logic [UW-1:0] ONE_U = UW'(1);

  // a pair needs both halves present in the same window
  for (genvar i = 0; i < WIN - 1; i++) begin : g_pair
    assign pair_head[i] = vld[i] && vld[i+1] &&
                          (insn_cls_t'(cls[i]) == CLS_CMP) && (uops[i] == ONE_U) &&
                          (insn_cls_t'(cls[i+1]) == CLS_JCC) && (uops[i+1] == ONE_U);
  end
  assign pair_head[WIN-1] = 1'b0;
endmodule

// File: rtl/dec_slot_alloc.sv
module dec_slot_alloc #(
  parameter int WIN      = 6,
  parameter int UW       = 3,
  parameter int SLOTS    = 4,
  parameter int CPLX_MAX = 4,
  localparam int PW      = $clog2(WIN)
) (
  input  logic [WIN-1:0]   vld,
  input  logic [UW-1:0]    uops [WIN],
  input  logic [WIN-1:0]   pair_head,
  output logic [SLOTS-1:0] s_vld,
  output logic [PW-1:0]    s_pos  [SLOTS],
  output logic [UW-1:0]    s_uops [SLOTS],
  output logic [SLOTS-1:0] s_fused,
  output logic             escape,
  output logic [PW:0]      used
);
  localparam logic [UW-1:0] ONE_U  = UW'(1);
  localparam logic [UW-1:0] CPLX_U = UW'(CPLX_MAX);
  localparam logic [PW:0]   WIN_P  = (PW+1)'(WIN);
  localparam logic [PW:0]   STEP1  = (PW+1)'(1);
  localparam logic [PW:0]   STEP2  = (PW+1)'(2);

  logic [PW:0]   ptr;
  logic          halt;
  logic          take;
  logic          fz;
  logic [UW-1:0] cnt;

  always_comb begin
    ptr     = '0;
    halt    = 1'b0;
    s_vld   = '0;
    s_fused = '0;
    escape  = 1'b0;
    take    = 1'b0;
    fz      = 1'b0;
    cnt     = '0;
    for (int s = 0; s < SLOTS; s++) begin
      s_pos[s]  = '0;
      s_uops[s] = '0;
    end
    for (int s = 0; s < SLOTS; s++) begin
      take = 1'b0;
      fz   = 1'b0;
      cnt  = '0;
      if (!halt && (ptr < WIN_P) && vld[ptr[PW-1:0]]) begin
        fz  = pair_head[ptr[PW-1:0]];
        cnt = fz ? ONE_U : uops[ptr[PW-1:0]];
        if (s == 0) begin
          take = 1'b1;
          if (cnt > CPLX_U) begin
            escape = 1'b1;
            halt   = 1'b1;
          end
        end else if (cnt == ONE_U) begin
          take = 1'b1;
        end else begin
          halt = 1'b1;
        end
      end else begin
        halt = 1'b1;
      end
      if (take) begin
        s_vld[s]   = 1'b1;
        s_pos[s]   = ptr[PW-1:0];
        s_uops[s]  = cnt;
        s_fused[s] = fz;
        ptr        = fz ? (ptr + STEP2) : (ptr + STEP1);
      end
    end
    used = ptr;
  end
endmodule

// File: rtl/dec_out_stage.sv
module dec_out_stage #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ready,
  input  logic [BW-1:0] din,
  output logic          valid,
  output logic [BW-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout)));
endmodule

// File: rtl/dec_slot_steer.sv
module dec_slot_steer #(
  parameter int WIN      = 6,
  parameter int UW       = 3,
  parameter int SLOTS    = 4,
  parameter int CPLX_MAX = 4,
  localparam int PW      = $clog2(WIN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIN-1:0]      win_vld,
  input  logic [WIN*UW-1:0]   win_uops,
  input  logic [WIN*2-1:0]    win_cls,
  output logic [PW:0]         take_cnt,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SLOTS-1:0]    out_slot_vld,
  output logic [SLOTS*PW-1:0] out_slot_pos,
  output logic [SLOTS*UW-1:0] out_slot_uops,
  output logic [SLOTS-1:0]    out_slot_fused,
  output logic                out_escape
);
  localparam int BW = 2*SLOTS + SLOTS*PW + SLOTS*UW + 1;
  localparam logic [UW-1:0] CPLX_U = UW'(CPLX_MAX);
  localparam logic [UW-1:0] ONE_U  = UW'(1);

  logic [UW-1:0]    uops_a [WIN];
  logic [1:0]       cls_a  [WIN];
  logic [WIN-1:0]   pair_head;
  logic [SLOTS-1:0] s_vld;
  logic [PW-1:0]    s_pos  [SLOTS];
  logic [UW-1:0]    s_uops [SLOTS];
  logic [SLOTS-1:0] s_fused;
  logic             escape;
  logic [PW:0]      used;
  logic [SLOTS*PW-1:0] pos_flat;
  logic [SLOTS*UW-1:0] uops_flat;
  logic             reg_free;
  logic             load;
  logic [BW-1:0]    bundle_in;
  logic [BW-1:0]    bundle_out;

  for (genvar i = 0; i < WIN; i++) begin : g_unpack
    assign uops_a[i] = win_uops[i*UW +: UW];
    assign cls_a[i]  = win_cls[i*2 +: 2];
  end

  dec_fuse_detect #(.WIN(WIN), .UW(UW)) fuse_i (
    .vld(win_vld), .uops(uops_a), .cls(cls_a), .pair_head(pair_head)
  );

  dec_slot_alloc #(.WIN(WIN), .UW(UW), .SLOTS(SLOTS), .CPLX_MAX(CPLX_MAX)) alloc_i (
    .vld(win_vld), .uops(uops_a), .pair_head(pair_head),
    .s_vld(s_vld), .s_pos(s_pos), .s_uops(s_uops), .s_fused(s_fused),
    .escape(escape), .used(used)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_pack
    assign pos_flat[s*PW +: PW]  = s_pos[s];
    assign uops_flat[s*UW +: UW] = s_uops[s];
  end

  // consume only when the output register can take a new beat
  assign reg_free  = !out_valid || out_ready;
  assign load      = rst_n && reg_free && s_vld[0];
  assign take_cnt  = load ? used : '0;
  assign bundle_in = {escape, s_fused, uops_flat, pos_flat, s_vld};

  dec_out_stage #(.BW(BW)) out_i (
    .clk(clk), .rst_n(rst_n), .load(load), .ready(out_ready),
    .din(bundle_in), .valid(out_valid), .dout(bundle_out)
  );

  assign {out_escape, out_slot_fused, out_slot_uops, out_slot_pos, out_slot_vld} = bundle_out;

  // R8
  no_take_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> (take_cnt == '0));

  // R6
  escape_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_escape) |-> ((out_slot_vld == SLOTS'(1)) && (out_slot_uops[UW-1:0] > CPLX_U)));

  // R5
  head_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_slot_vld[0]);

  for (genvar s = 1; s < SLOTS; s++) begin : g_slot_chk
    // R3
    simple_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_slot_vld[s]) |-> (out_slot_uops[s*UW +: UW] == ONE_U));
    // R5
    slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_slot_vld[s]) |->
        (out_slot_vld[s-1] && (out_slot_pos[s*PW +: PW] > out_slot_pos[(s-1)*PW +: PW])));
  end

  for (genvar i = 1; i < WIN; i++) begin : g_win_chk
    // R9
    win_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld[i] |-> win_vld[i-1]);
  end
endmodule

// File: tb/dec_slot_steer_tb_top.sv
`timescale 1ns/1ps
module dec_slot_steer_tb_top;
  localparam int WIN = 6;
  localparam int UW = 3;
  localparam int SLOTS = 4;
  localparam int PW = $clog2(WIN);
  localparam int NPROG = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WIN-1:0] win_vld = '0;
  logic [WIN*UW-1:0] win_uops = '0;
  logic [WIN*2-1:0] win_cls = '0;
  logic [PW:0] take_cnt;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [SLOTS-1:0] out_slot_vld;
  logic [SLOTS*PW-1:0] out_slot_pos;
  logic [SLOTS*UW-1:0] out_slot_uops;
  logic [SLOTS-1:0] out_slot_fused;
  logic out_escape;

  always #2.5 clk = ~clk;

  dec_slot_steer #(.WIN(WIN), .UW(UW), .SLOTS(SLOTS), .CPLX_MAX(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_uops(win_uops), .win_cls(win_cls),
    .take_cnt(take_cnt), .out_valid(out_valid), .out_ready(out_ready),
    .out_slot_vld(out_slot_vld), .out_slot_pos(out_slot_pos), .out_slot_uops(out_slot_uops),
    .out_slot_fused(out_slot_fused), .out_escape(out_escape)
  );

  int checks = 0;
  int failures = 0;
  int p_cls[NPROG];
  int p_uops[NPROG];
  int nprog = 0;

  // window seen this cycle
  int w_n;
  int w_cls[WIN];
  int w_uops[WIN];
  // freshly steered group
  int e_n, e_cnt, e_esc;
  int e_vld[SLOTS], e_pos[SLOTS], e_u[SLOTS], e_f[SLOTS];
  // model of the output register
  int m_valid, m_esc;
  int m_vld[SLOTS], m_pos[SLOTS], m_u[SLOTS], m_f[SLOTS];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic add(input int c, input int u);
    if (nprog < NPROG) begin
      p_cls[nprog] = c;
      p_uops[nprog] = u;
      nprog++;
    end
  endtask

  // units first, then slot placement
  task automatic steer();
    int ustart[$], uwid[$], ucnt[$], ufz[$];
    int i;
    i = 0;
    while (i < w_n) begin
      if (i + 1 < w_n && w_cls[i] == 1 && w_uops[i] == 1 && w_cls[i+1] == 2 && w_uops[i+1] == 1) begin
        ustart.push_back(i); uwid.push_back(2); ucnt.push_back(1); ufz.push_back(1);
        i += 2;
      end else begin
        ustart.push_back(i); uwid.push_back(1); ucnt.push_back(w_uops[i]); ufz.push_back(0);
        i += 1;
      end
    end
    e_n = 0; e_cnt = 0; e_esc = 0;
    for (int s = 0; s < SLOTS; s++) begin
      e_vld[s] = 0; e_pos[s] = 0; e_u[s] = 0; e_f[s] = 0;
    end
    for (int k = 0; k < ustart.size() && e_cnt < SLOTS; k++) begin
      if (k > 0 && (ucnt[k] != 1 || e_esc == 1)) break;
      e_vld[e_cnt] = 1; e_pos[e_cnt] = ustart[k]; e_u[e_cnt] = ucnt[k]; e_f[e_cnt] = ufz[k];
      e_n += uwid[k];
      if (k == 0 && ucnt[k] > 4) e_esc = 1;
      e_cnt++;
    end
  endtask

  task automatic compare_out();
    chk(out_valid == m_valid[0], "R7 out_valid", out_valid, m_valid);
    if (m_valid != 0 && out_valid) begin
      chk(out_escape == m_esc[0], "R6 escape", out_escape, m_esc);
      for (int s = 0; s < SLOTS; s++) begin
        chk(out_slot_vld[s] == m_vld[s][0], "R3 slot valid", out_slot_vld[s], m_vld[s]);
        if (m_vld[s] != 0) begin
          chk(int'(out_slot_pos[s*PW +: PW]) == m_pos[s], "R5 slot position",
              int'(out_slot_pos[s*PW +: PW]), m_pos[s]);
          chk(int'(out_slot_uops[s*UW +: UW]) == m_u[s], "R2 slot uop count",
              int'(out_slot_uops[s*UW +: UW]), m_u[s]);
          chk(out_slot_fused[s] == m_f[s][0], "R4 fused bit", out_slot_fused[s], m_f[s]);
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int head, lim, rdy, free, exp_take, cyc;
    // directed prefix
    add(0,1); add(1,1); add(2,1); add(0,3);          // R4 pair, then R3 multi stops group
    add(0,1); add(3,1); add(0,1); add(2,1);          // simple fill, lone jump
    add(0,6); add(0,1); add(0,1);                    // R6 escape alone
    add(1,2); add(2,1); add(0,1);                    // multi-uop compare is not fused
    add(0,4); add(1,1); add(2,1); add(1,1); add(2,1); add(0,1);
    add(0,1); add(0,1); add(0,1); add(0,1); add(1,1); // compare near the window edge
    add(2,1); add(0,7); add(0,2); add(0,1); add(0,5);
    while (nprog < NPROG) begin
      int r, c, u;
      r = $urandom_range(0, 99);
      c = (r < 45) ? 0 : (r < 68) ? 1 : (r < 85) ? 2 : 3;
      r = $urandom_range(0, 99);
      u = (r < 70) ? 1 : (r < 92) ? $urandom_range(2, 4) : $urandom_range(5, 7);
      add(c, u);
    end

    // R1: reset state with a full window presented
    win_vld = '1;
    for (int i = 0; i < WIN; i++) begin
      win_uops[i*UW +: UW] = UW'(1);
      win_cls[i*2 +: 2] = 2'd0;
    end
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(take_cnt == '0, "R1 take_cnt in reset", int'(take_cnt), 0);
    rst_n = 1'b1;
    win_vld = '0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

    m_valid = 0; m_esc = 0;
    for (int s = 0; s < SLOTS; s++) begin
      m_vld[s] = 0; m_pos[s] = 0; m_u[s] = 0; m_f[s] = 0;
    end
    head = 0;
    cyc = 0;
    while ((head < nprog || m_valid != 0) && cyc < 20000) begin
      cyc++;
      // R7: stall bursts plus random back-pressure
      if ((cyc % 97) >= 80) rdy = 0;
      else rdy = ($urandom_range(0, 99) < 70) ? 1 : 0;
      // R9: fetch bubbles shrink the window
      lim = ($urandom_range(0, 99) < 20) ? $urandom_range(0, WIN) : WIN;
      w_n = 0;
      win_vld = '0;
      for (int i = 0; i < WIN; i++) begin
        if (i < lim && head + i < nprog) begin
          w_cls[i] = p_cls[head+i];
          w_uops[i] = p_uops[head+i];
          win_vld[i] = 1'b1;
          win_cls[i*2 +: 2] = 2'(w_cls[i]);
          win_uops[i*UW +: UW] = UW'(w_uops[i]);
          w_n++;
        end else begin
          w_cls[i] = 0;
          w_uops[i] = 0;
          win_cls[i*2 +: 2] = 2'd0;
          win_uops[i*UW +: UW] = '0;
        end
      end
      out_ready = rdy[0];
      #1;
      steer();
      free = (m_valid == 0 || rdy != 0) ? 1 : 0;
      exp_take = (free != 0) ? e_n : 0;
      // R8 consumption count (R7 covers the stalled zero)
      chk(int'(take_cnt) == exp_take, "R8 take_cnt", int'(take_cnt), exp_take);
      compare_out();
      @(posedge clk);
      if (free != 0) begin
        if (e_cnt > 0) begin
          m_valid = 1; m_esc = e_esc;
          for (int s = 0; s < SLOTS; s++) begin
            m_vld[s] = e_vld[s]; m_pos[s] = e_pos[s]; m_u[s] = e_u[s]; m_f[s] = e_f[s];
          end
        end else begin
          m_valid = 0;
        end
      end
      head += exp_take;
      @(negedge clk);
    end
    chk(head == nprog, "R8 whole program consumed", head, nprog);
    // R9: empty window drains the output
    win_vld = '0;
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 idle after drain", out_valid, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule